// File: doc/BRIEF.md
# Serial Frame Transmitter with Preamble and Break Generation

This block is the transmit half of an asynchronous serial port. It takes a parallel word of 8 or 9 data bits through a valid/ready handshake. It stores the word in a one-entry holding register. It then shifts the word out on a single line, with one start bit of 0 and one stop bit of 1. An external baud tick paces the output, and every bit lasts sixteen ticks.

Beyond plain data, the block makes three special frames:

- **Preamble (idle frame).** An all-ones frame, one full frame long. It is sent whenever the effective transmit enable rises, and this includes a re-enable that happens while a frame is still going out.
- **Break frame.** An all-zeros frame, sent on request. A held request sends break frames back to back.
- **Release bit.** A single high bit-time that closes a run of breaks.

A module enable gates every write to the transmit enable. Two status outputs report the state of the block:

- `hold_free` shows that the holding register can take a new word.
- `line_idle` shows that the line is at rest and no work is pending.

Top module: `sertx_top`

## Requirements
- R1: When the effective transmit enable goes from 0 to 1, the next frame sent is an all-ones preamble of 10 bit-times, or 11 bit-times when `nine_bit` is 1 at the moment that frame is loaded.
- R2: Clearing `tx_en` while a frame is on the line lets that frame finish. After it, `txd` stays at 1 and no further frame starts until the enable is set again.
- R3: Clearing and then setting the enable while a frame is in flight queues exactly one all-ones idle frame. That idle frame starts on the bit boundary right after the current frame ends.
- R4: A single-cycle `brk_req` pulse produces one break frame: 10 or 11 bit-times of 0, covering the start and stop positions. One bit-time of 1 follows it, and then the line rests or the next frame starts.
- R5: While `brk_req` stays high, break frames follow each other with no 1 bit between them.
- R6: While `mod_en` is 0, changes on `tx_en` have no effect. Raising `tx_en` in that state starts no preamble, and `txd` stays at 1.
- R7: A break request made while a preamble is pending and has not yet started replaces that preamble. The break goes out and the preamble is dropped.
- R8: After reset, the transmit enable and the break request are both cleared, `txd` is 1, `hold_free` is 1 and `line_idle` is 1.
- R9: A data frame is made of a start bit 0, then the data bits LSB first (8 bits, or 9 when `nine_bit` is 1 at load time), then a stop bit 1. Each bit lasts 16 `baud_tick` pulses.
- R10: A word is accepted in any cycle where `data_valid` and `hold_free` are both 1. In that case `hold_free` is 0 in the next cycle and stays 0 until the word moves into the shifter.
- R11: `line_idle` is 1 only when no frame is on the line, the holding register is empty, and no break or idle frame is pending. Whenever `line_idle` is 1, `txd` is 1.
- R12: When several frames are ready at a frame boundary, they go out in this order: the release bit, then a pending break, then a pending idle or preamble frame, then buffered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse; 16 pulses make one bit-time |
| mod_en | input | 1 | Module enable; while it is low, `tx_en` is not sampled |
| tx_en | input | 1 | Requested transmit enable |
| brk_req | input | 1 | Break request; a pulse sends one break, holding it streams breaks |
| nine_bit | input | 1 | 1 selects 9 data bits; sampled when a frame is loaded |
| data_in | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| data_valid | input | 1 | Data word offered |
| hold_free | output | 1 | Holding register empty; doubles as ready |
| txd | output | 1 | Serial output; idle level is 1 |
| line_idle | output | 1 | Shifter idle and nothing pending |

## Verification
Two things can need the shifter at the same frame boundary. One is a break request. The other is either a buffered data word or a preamble that the enable has just armed. The bench provokes this in two ways. It loads a word while a frame is running and pulses `brk_req` in the same frame. It also raises the enable and the break request in the same cycle. A behavioural reference, built from bit queues, predicts `txd`, `hold_free` and `line_idle` on every clock. The bench judges the result by whether the zero frame comes first, whether the release bit follows it, and whether the data frame is delayed rather than lost, while the preamble is dropped.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W   = 9;
    localparam int MAX_BITS = DATA_W + 2;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);

    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_IDLE  = 2'd1,
        FK_BREAK = 2'd2,
        FK_TAIL  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] bits;
        logic [LEN_W-1:0]    len;
        frame_kind_e         kind;
    } frame_t;

    function automatic frame_t build_frame(frame_kind_e k, logic nine, logic [DATA_W-1:0] d);
        frame_t f;
        f.kind = k;
        f.len  = nine ? LEN_W'(MAX_BITS) : LEN_W'(MAX_BITS - 1);
        f.bits = '1;
        case (k)
            FK_DATA: begin
                f.bits[0] = 1'b0;
                for (int i = 0; i < DATA_W - 1; i++) f.bits[i+1] = d[i];
                f.bits[DATA_W] = nine ? d[DATA_W-1] : 1'b1;
            end
            FK_BREAK: f.bits = '0;
            FK_TAIL:  f.len  = LEN_W'(1);
            default:  f.bits = '1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        load,
    input  frame_t      frame,
    output logic        txd,
    output logic        busy,
    output logic        last_edge,
    output frame_kind_e cur_kind
);
    localparam int TCNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [MAX_BITS-1:0] sh;
    logic [LEN_W-1:0]    left;
    logic [TCNT_W-1:0]   tcnt;
    logic                bit_end;

    assign busy      = (left != '0);
    assign bit_end   = busy && tick && (tcnt == TCNT_W'(TICKS - 1));
    assign last_edge = bit_end && (left == LEN_W'(1));
    assign txd       = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '1;
            left     <= '0;
            tcnt     <= '0;
            cur_kind <= FK_IDLE;
        end else if (load) begin
            sh       <= frame.bits;
            left     <= frame.len;
            tcnt     <= '0;
            cur_kind <= frame.kind;
        end else if (bit_end) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[MAX_BITS-1:1]};
            left <= left - LEN_W'(1);
        end else if (busy && tick) begin
            tcnt <= tcnt + TCNT_W'(1);
        end
    end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_en,
    input  logic        tx_en,
    input  logic        brk_req,
    input  logic        busy,
    input  logic        last_edge,
    input  frame_kind_e cur_kind,
    input  logic        hold_full,
    output logic        load,
    output frame_kind_e load_kind,
    output logic        pop,
    output logic        te_q,
    output logic        brk_pend,
    output logic        idle_want
);
    logic te_d;
    logic idle_pend;
    logic free;
    logic need_tail;

    assign free      = !busy || last_edge;
    assign idle_want = idle_pend || (te_q && !te_d);
    assign need_tail = last_edge && (cur_kind == FK_BREAK) && !brk_pend;

    always_comb begin
        load      = 1'b0;
        load_kind = FK_DATA;
        pop       = 1'b0;
        if (free) begin
            if (need_tail) begin
                load      = 1'b1;
                load_kind = FK_TAIL;
            end else if (te_q) begin
                if (brk_pend) begin
                    load      = 1'b1;
                    load_kind = FK_BREAK;
                end else if (idle_want) begin
                    load      = 1'b1;
                    load_kind = FK_IDLE;
                end else if (hold_full) begin
                    load      = 1'b1;
                    load_kind = FK_DATA;
                    pop       = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            te_q      <= 1'b0;
            te_d      <= 1'b0;
            brk_pend  <= 1'b0;
            idle_pend <= 1'b0;
        end else begin
            if (mod_en) te_q <= tx_en;
            te_d      <= te_q;
            brk_pend  <= brk_req || (brk_pend && !(load && load_kind == FK_BREAK));
            idle_pend <= idle_want && !(load && (load_kind == FK_IDLE || load_kind == FK_BREAK));
        end
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              mod_en,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              nine_bit,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_valid,
    output logic              hold_free,
    output logic              txd,
    output logic              line_idle
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              pop;
    logic              load;
    frame_kind_e       load_kind;
    frame_kind_e       cur_kind;
    frame_t            next_frame;
    logic              shifter_busy;
    logic              last_edge;
    logic              te_q;
    logic              brk_pend;
    logic              idle_want;

    sertx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (data_valid),
        .wr_data  (data_in),
        .pop      (pop),
        .full     (hold_full),
        .data     (hold_data)
    );

    sertx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mod_en    (mod_en),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .busy      (shifter_busy),
        .last_edge (last_edge),
        .cur_kind  (cur_kind),
        .hold_full (hold_full),
        .load      (load),
        .load_kind (load_kind),
        .pop       (pop),
        .te_q      (te_q),
        .brk_pend  (brk_pend),
        .idle_want (idle_want)
    );

    assign next_frame = build_frame(load_kind, nine_bit, hold_data);

    sertx_shifter #(.TICKS(TICKS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .load      (load),
        .frame     (next_frame),
        .txd       (txd),
        .busy      (shifter_busy),
        .last_edge (last_edge),
        .cur_kind  (cur_kind)
    );

    assign hold_free = !hold_full;
    assign line_idle = !shifter_busy && !hold_full && !idle_want && !brk_pend;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       mod_en,
    input logic       data_valid,
    input logic       hold_free,
    input logic       line_idle,
    input logic       txd,
    input logic       te_q,
    input logic       brk_pend,
    input logic       busy,
    input logic [1:0] cur_kind
);
    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            // R8
            reset_state_chk: assert (!te_q && !brk_pend && txd && hold_free);
        end
    end

    // R10
    accept_full_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid && hold_free) |=> !hold_free);

    // R6
    enable_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !mod_en |=> (te_q == $past(te_q)));

    // R11
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        line_idle |-> txd);

    // R5
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == 2'(FK_BREAK)) |-> !txd);
endmodule

bind sertx_top sertx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mod_en     (mod_en),
    .data_valid (data_valid),
    .hold_free  (hold_free),
    .line_idle  (line_idle),
    .txd        (txd),
    .te_q       (te_q),
    .brk_pend   (brk_pend),
    .busy       (shifter_busy),
    .cur_kind   (cur_kind)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       mod_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       nine_bit = 1'b0;
    logic [8:0] data_in = '0;
    logic       data_valid = 1'b0;
    logic       hold_free, txd, line_idle;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R8";
    bit done = 0;

    always #4 clk = ~clk;

    sertx_top dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .mod_en(mod_en),
        .tx_en(tx_en), .brk_req(brk_req), .nine_bit(nine_bit),
        .data_in(data_in), .data_valid(data_valid),
        .hold_free(hold_free), .txd(txd), .line_idle(line_idle)
    );

    always @(negedge clk) begin
        if (rst) baud_tick <= 1'b0;
        else     baud_tick <= ~baud_tick;
    end

    // behavioural reference: kinds 0 data, 1 idle, 2 break, 3 release bit
    int m_q[$];
    int m_tcnt, m_kind;
    bit m_te, m_ted, m_brkp, m_idlep, m_full;
    logic [8:0] m_data;

    always @(posedge clk) begin
        bit busy, last, free, rise, iw, tail, acc;
        int sel, n;
        if (rst) begin
            m_q.delete(); m_tcnt = 0; m_kind = 1;
            m_te = 0; m_ted = 0; m_brkp = 0; m_idlep = 0; m_full = 0; m_data = '0;
        end else begin
            busy = (m_q.size() > 0);
            last = busy && baud_tick && m_tcnt == 15 && m_q.size() == 1;
            free = !busy || last;
            rise = m_te && !m_ted;
            iw   = m_idlep || rise;
            tail = last && m_kind == 2 && !m_brkp;
            sel  = -1;
            if (free) begin
                if (tail) sel = 3;
                else if (m_te) begin
                    if (m_brkp) sel = 2;
                    else if (iw) sel = 1;
                    else if (m_full) sel = 0;
                end
            end
            if (busy && baud_tick) begin
                if (m_tcnt == 15) begin m_tcnt = 0; void'(m_q.pop_front()); end
                else m_tcnt++;
            end
            if (sel >= 0) begin
                m_q.delete(); m_tcnt = 0; m_kind = sel;
                n = nine_bit ? 9 : 8;
                if (sel == 3) m_q.push_back(1);
                else if (sel == 0) begin
                    m_q.push_back(0);
                    for (int i = 0; i < n; i++) m_q.push_back(int'(m_data[i]));
                    m_q.push_back(1);
                end else begin
                    for (int i = 0; i < n + 2; i++) m_q.push_back(sel == 2 ? 0 : 1);
                end
            end
            acc     = data_valid && !m_full;
            m_brkp  = brk_req || (m_brkp && sel != 2);
            m_idlep = iw && !(sel == 1 || sel == 2);
            if (sel == 0) m_full = 0;
            else if (acc) begin m_full = 1; m_data = data_in; end
            m_ted = m_te;
            if (mod_en) m_te = tx_en;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int e_txd, e_free, e_idle;
        cycles++;
        if (!rst && !done) begin
            e_txd  = (m_q.size() > 0) ? m_q[0] : 1;
            e_free = !m_full;
            e_idle = (m_q.size() == 0) && !m_full && !(m_idlep || (m_te && !m_ted)) && !m_brkp;
            check(txd == e_txd, {phase, " txd"}, txd, e_txd);
            check(hold_free == e_free, {phase, " R10 hold_free"}, hold_free, e_free);
            check(line_idle == e_idle, {phase, " R11 line_idle"}, line_idle, e_idle);
        end
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [8:0] d);
        while (!hold_free) cyc(1);
        data_in = d; data_valid = 1'b1;
        cyc(1);
        data_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (!line_idle && k < 20000) begin cyc(1); k++; end
        cyc(40);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R8 reset state at the ports
        check(txd == 1'b1, "R8 txd after reset", txd, 1);
        check(hold_free == 1'b1, "R8 hold_free after reset", hold_free, 1);
        check(line_idle == 1'b1, "R8 line_idle after reset", line_idle, 1);

        // R6 enable writes ignored while module disabled
        phase = "R6";
        tx_en = 1'b1;
        cyc(120);
        check(txd == 1'b1, "R6 no preamble while disabled", txd, 1);

        // R1 preamble then R9 8-bit data
        phase = "R1";
        mod_en = 1'b1;
        cyc(3);
        phase = "R9";
        send(9'h0A5);
        wait_idle();

        // R9 9-bit frames, R10 back-to-back handshake
        phase = "R9";
        nine_bit = 1'b1;
        send(9'h1C3);
        send(9'h0F0);
        wait_idle();
        nine_bit = 1'b0;

        // R3 toggle enable mid-frame queues one idle frame
        phase = "R3";
        send(9'h055);
        cyc(100);
        tx_en = 1'b0; cyc(1); tx_en = 1'b1;
        wait_idle();

        // R2 clear enable mid-frame: frame finishes, line rests
        phase = "R2";
        send(9'h0C3);
        cyc(60);
        tx_en = 1'b0;
        cyc(600);
        check(txd == 1'b1, "R2 line high after disable", txd, 1);
        tx_en = 1'b1;
        wait_idle();

        // R4 single break pulse
        phase = "R4";
        brk_req = 1'b1; cyc(1); brk_req = 1'b0;
        wait_idle();

        // R5 held break streams frames
        phase = "R5";
        brk_req = 1'b1; cyc(1100); brk_req = 1'b0;
        wait_idle();

        // R7 break before preamble replaces it
        phase = "R7";
        tx_en = 1'b0; cyc(4);
        tx_en = 1'b1; brk_req = 1'b1; cyc(1); brk_req = 1'b0;
        wait_idle();

        // R12 break and buffered data meet at one boundary
        phase = "R12";
        nine_bit = 1'b1;
        send(9'h12D);
        cyc(30);
        send(9'h0E1);
        brk_req = 1'b1; cyc(1); brk_req = 1'b0;
        wait_idle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule